// File: doc/BRIEF.md
# Multi-Source Configurable I/O Port

This block is one 8-bit bidirectional port of a peripheral that sits on a microcontroller bus. Every pin is set up on its own. Its output comes from one of four places: a data register written by the CPU, a byte of the bus address captured on an address-latch-enable strobe, an output of the macrocell logic, or one of three external chip-select lines. A per-pin enable decides whether the pin is driven at all. The enable is the OR of a CPU-written direction bit and an external output-enable term. When a pin is not driven, it acts as an input.

The CPU reaches the port through a small register window. It writes the control, direction and data-out registers. It reads back exactly one internal source at a time: the synchronized pin levels, any of the three registers, or the live macrocell outputs. A static 2-bit source field per pin picks the output source. A set control bit overrides that field and forces the pin to take the latched address. The tri-state driver is exposed as separate output-value and output-enable vectors. The raw pin level is also passed on to the macrocell input path.

Top module: `cfg_io_port`

## Requirements
- R1: After reset, the control, direction and data-out registers read as zero. With ext_oe at zero, every pin_oe bit is zero.
- R2: A write with cpu_wr high loads cpu_wdata on the next clock edge into the addressed register. The offsets are control at 1, direction at 2 and data-out at 3. Reading the same offset returns the stored value.
- R3: A read at offset 0 returns the pin levels through a two-flop synchronizer. A change on pin_in becomes visible after the second rising edge, not after the first.
- R4: A read at offset 4 returns mcell_out live. Reads at offsets 5, 6 and 7 return zero.
- R5: When its control bit is zero, pin i takes its source from src_cfg[2i+1:2i]. The codes are 00 for the data-out bit, 01 for the latched address bit, 10 for mcell_out[i] and 11 for ext_cs[i].
- R6: Only pins 0, 1 and 2 have a chip-select line. A pin from 3 to 7 that is set to code 11 drives 0.
- R7: When a pin's control bit is 1, the pin drives its latched address bit whatever its src_cfg code.
- R8: The address latch is transparent. While ale is high, bus_addr passes straight through. Once ale has been high across a clock edge and then drops, the value from that edge is held until ale rises again.
- R9: pin_oe[i] is 1 exactly when the direction bit i or ext_oe[i] is 1.
- R10: logic_in follows pin_in combinationally.
- R11: Writes to offsets 0, 4, 5, 6 and 7 change no register and no pin output or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 3 | Register offset |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from cpu_addr |
| bus_addr | input | 8 | Address byte to be latched |
| ale | input | 1 | Address-latch enable, transparent when high |
| mcell_out | input | 8 | Macrocell outputs |
| ext_cs | input | 3 | External chip-select lines for pins 0 to 2 |
| ext_oe | input | 8 | External output-enable term per pin |
| src_cfg | input | 16 | Static 2-bit source code per pin |
| pin_in | input | 8 | Level sensed at the pins |
| pin_out | output | 8 | Value driven on the pins |
| pin_oe | output | 8 | Driver enable per pin |
| logic_in | output | 8 | Pin level passed on to the macrocell inputs |

## Verification
The output selector is first driven with uniform source codes, all data register, all address, all macrocell and all chip-select. It is then driven with a mixed code pattern, in which one byte holds every source at once. The data-out, address and macrocell values are chosen to be disjoint, so a swapped select code or a wrong pin index shows up as a wrong bit. The chip-select pattern is applied across all eight pins, which separates the three wired lines from the five pins that must stay at zero. The control override is tried on half the pins against a nonzero data-out value. Separate steps hold ale low while bus_addr changes and sample the synchronized readback after one edge and after two.

// File: rtl/cio_pkg.sv
package cio_pkg;

    localparam int PORT_W  = 8;
    localparam int CS_W    = 3;
    localparam int RA_W    = 3;

    typedef enum logic [1:0] {
        SRC_DOUT  = 2'b00,
        SRC_ADDR  = 2'b01,
        SRC_MCELL = 2'b10,
        SRC_CS    = 2'b11
    } src_e;

    typedef enum logic [RA_W-1:0] {
        RA_DIN   = 3'd0,
        RA_CTRL  = 3'd1,
        RA_DIR   = 3'd2,
        RA_DOUT  = 3'd3,
        RA_MCELL = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [PORT_W-1:0] ctrl;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] dout;
    } port_regs_t;

    // Effective source of one pin: a set control bit forces the address path.
    function automatic src_e pick_src(input logic force_addr, input logic [1:0] cfg);
        if (force_addr) return SRC_ADDR;
        return src_e'(cfg);
    endfunction

endpackage

// File: rtl/cio_regs.sv
module cio_regs
    import cio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [RA_W-1:0]     addr,
    input  logic [PORT_W-1:0]   wdata,
    output port_regs_t          regs
);

    port_regs_t regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr) begin
            case (reg_addr_e'(addr))
                RA_CTRL: regs_q.ctrl <= wdata;
                RA_DIR:  regs_q.dir  <= wdata;
                RA_DOUT: regs_q.dout <= wdata;
                default: ;
            endcase
        end
    end

    assign regs = regs_q;

    // R11: a write outside the writable offsets leaves every register unchanged
    p_ignored_write_r11: assert property (@(posedge clk) disable iff (rst)
        (wr && !(addr inside {RA_CTRL, RA_DIR, RA_DOUT})) |=> $stable(regs_q));

endmodule

// File: rtl/cio_addr_latch.sv
module cio_addr_latch
    import cio_pkg::*;
#(
    parameter int W = PORT_W
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         ale,
    input  logic [W-1:0] bus_addr,
    output logic [W-1:0] addr_q
);

    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst)      held_q <= '0;
        else if (ale) held_q <= bus_addr;
    end

    // Transparent while ale is high, holding the last captured byte otherwise.
    assign addr_q = ale ? bus_addr : held_q;

    // R8: with ale low on two consecutive edges, the latched byte does not move
    p_latch_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !ale |=> (ale || $stable(addr_q)));

endmodule

// File: rtl/cio_sync.sv
module cio_sync
    import cio_pkg::*;
#(
    parameter int W = PORT_W
)(
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;

    // R3: an input held steady across two edges is presented at the output
    p_sync_settle_r3: assert property (@(posedge clk) disable iff (rst)
        ((d == $past(d)) && ($past(d) == $past(d, 2))) |-> (q == d));

endmodule

// File: rtl/cio_pin_slice.sv
module cio_pin_slice
    import cio_pkg::*;
#(
    parameter bit HAS_CS = 1'b1
)(
    input  logic       dout_bit,
    input  logic       addr_bit,
    input  logic       mcell_bit,
    input  logic       cs_bit,
    input  logic       ctrl_bit,
    input  logic [1:0] cfg,
    input  logic       dir_bit,
    input  logic       ext_oe_bit,
    output logic       out_bit,
    output logic       oe_bit
);

    src_e sel;
    logic cs_src;

    assign sel = pick_src(ctrl_bit, cfg);

    generate
        if (HAS_CS) begin : g_cs
            assign cs_src = cs_bit;
        end else begin : g_no_cs
            assign cs_src = 1'b0;
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SRC_DOUT:  out_bit = dout_bit;
            SRC_ADDR:  out_bit = addr_bit;
            SRC_MCELL: out_bit = mcell_bit;
            SRC_CS:    out_bit = cs_src;
            default:   out_bit = 1'b0;
        endcase
    end

    assign oe_bit = dir_bit | ext_oe_bit;

    // R7: a set control bit always routes the address bit to the pin
    always_comb begin
        p_ctrl_force_r7: assert (!ctrl_bit || (out_bit === addr_bit) || $isunknown(addr_bit));
    end

endmodule

// File: rtl/cio_readback.sv
module cio_readback
    import cio_pkg::*;
(
    input  logic [RA_W-1:0]   addr,
    input  port_regs_t        regs,
    input  logic [PORT_W-1:0] din_sync,
    input  logic [PORT_W-1:0] mcell,
    output logic [PORT_W-1:0] rdata
);

    always_comb begin
        case (reg_addr_e'(addr))
            RA_DIN:   rdata = din_sync;
            RA_CTRL:  rdata = regs.ctrl;
            RA_DIR:   rdata = regs.dir;
            RA_DOUT:  rdata = regs.dout;
            RA_MCELL: rdata = mcell;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port
    import cio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [RA_W-1:0]      cpu_addr,
    input  logic                 cpu_wr,
    input  logic [PORT_W-1:0]    cpu_wdata,
    output logic [PORT_W-1:0]    cpu_rdata,
    input  logic [PORT_W-1:0]    bus_addr,
    input  logic                 ale,
    input  logic [PORT_W-1:0]    mcell_out,
    input  logic [CS_W-1:0]      ext_cs,
    input  logic [PORT_W-1:0]    ext_oe,
    input  logic [2*PORT_W-1:0]  src_cfg,
    input  logic [PORT_W-1:0]    pin_in,
    output logic [PORT_W-1:0]    pin_out,
    output logic [PORT_W-1:0]    pin_oe,
    output logic [PORT_W-1:0]    logic_in
);

    port_regs_t        regs;
    logic [PORT_W-1:0] addr_lat;
    logic [PORT_W-1:0] din_sync;

    cio_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (cpu_wr),
        .addr  (cpu_addr),
        .wdata (cpu_wdata),
        .regs  (regs)
    );

    cio_addr_latch #(.W(PORT_W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .ale      (ale),
        .bus_addr (bus_addr),
        .addr_q   (addr_lat)
    );

    cio_sync #(.W(PORT_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (din_sync)
    );

    genvar i;
    generate
        for (i = 0; i < PORT_W; i++) begin : g_pin
            logic cs_line;
            if (i < CS_W) begin : g_cs_wire
                assign cs_line = ext_cs[i];
            end else begin : g_cs_none
                assign cs_line = 1'b0;
            end
            cio_pin_slice #(.HAS_CS(i < CS_W)) u_slice (
                .dout_bit   (regs.dout[i]),
                .addr_bit   (addr_lat[i]),
                .mcell_bit  (mcell_out[i]),
                .cs_bit     (cs_line),
                .ctrl_bit   (regs.ctrl[i]),
                .cfg        (src_cfg[2*i +: 2]),
                .dir_bit    (regs.dir[i]),
                .ext_oe_bit (ext_oe[i]),
                .out_bit    (pin_out[i]),
                .oe_bit     (pin_oe[i])
            );
        end
    endgenerate

    cio_readback u_rb (
        .addr     (cpu_addr),
        .regs     (regs),
        .din_sync (din_sync),
        .mcell    (mcell_out),
        .rdata    (cpu_rdata)
    );

    assign logic_in = pin_in;

    // R9: every direction bit just written turns its driver on
    p_dir_enable_r9: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == RA_DIR) |=> ((pin_oe & $past(cpu_wdata)) == $past(cpu_wdata)));

    // R2: the data-out value just written is what offset 3 returns
    p_dout_readback_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == RA_DOUT) |=> (cpu_addr != RA_DOUT || cpu_rdata == $past(cpu_wdata)));

    // R7: pins given a set control bit by a write follow the latched address
    p_ctrl_addr_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == RA_CTRL) |=> (((pin_out ^ addr_lat) & $past(cpu_wdata)) == '0));

endmodule

// File: tb/cfg_io_port_bench.sv
module cfg_io_port_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  cpu_addr;
    logic        cpu_wr;
    logic [7:0]  cpu_wdata;
    logic [7:0]  cpu_rdata;
    logic [7:0]  bus_addr;
    logic        ale;
    logic [7:0]  mcell_out;
    logic [2:0]  ext_cs;
    logic [7:0]  ext_oe;
    logic [15:0] src_cfg;
    logic [7:0]  pin_in;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;
    logic [7:0]  logic_in;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cfg_io_port u_cfg_io_port (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .bus_addr  (bus_addr),
        .ale       (ale),
        .mcell_out (mcell_out),
        .ext_cs    (ext_cs),
        .ext_oe    (ext_oe),
        .src_cfg   (src_cfg),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .logic_in  (logic_in)
    );

    task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wr    = 1'b1;
        @(negedge clk);
        cpu_wr    = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd_reg(3'd1, v); check("R1", "ctrl after reset", v, 8'h00);
        rd_reg(3'd2, v); check("R1", "dir after reset", v, 8'h00);
        rd_reg(3'd3, v); check("R1", "dout after reset", v, 8'h00);
        check("R1", "pin_oe after reset", pin_oe, 8'h00);
    endtask

    task automatic t_regs;
        logic [7:0] v;
        wr_reg(3'd1, 8'h00);
        wr_reg(3'd2, 8'h3C);
        wr_reg(3'd3, 8'hA5);
        rd_reg(3'd2, v); check("R2", "dir readback", v, 8'h3C);
        rd_reg(3'd3, v); check("R2", "dout readback", v, 8'hA5);
        wr_reg(3'd1, 8'h81);
        rd_reg(3'd1, v); check("R2", "ctrl readback", v, 8'h81);
        wr_reg(3'd1, 8'h00);
    endtask

    task automatic t_sync;
        logic [7:0] v;
        @(negedge clk);
        pin_in = 8'hC3;
        rd_reg(3'd0, v); check("R3", "din before any edge", v, 8'h00);
        @(negedge clk);
        rd_reg(3'd0, v); check("R3", "din after one edge", v, 8'h00);
        @(negedge clk);
        rd_reg(3'd0, v); check("R3", "din after two edges", v, 8'hC3);
    endtask

    task automatic t_rb_misc;
        logic [7:0] v;
        mcell_out = 8'h6D;
        rd_reg(3'd4, v); check("R4", "macrocell readback", v, 8'h6D);
        for (int k = 5; k < 8; k++) begin
            rd_reg(3'(k), v); check("R4", "unused offset reads zero", v, 8'h00);
        end
    endtask

    task automatic t_src_uniform;
        wr_reg(3'd2, 8'hFF);
        wr_reg(3'd3, 8'h5A);
        mcell_out = 8'h96;
        src_cfg = 16'h0000; #1; check("R5", "all data-out", pin_out, 8'h5A);
        src_cfg = 16'hAAAA; #1; check("R5", "all macrocell", pin_out, 8'h96);
        @(negedge clk); ale = 1'b1; bus_addr = 8'h3E;
        @(negedge clk); ale = 1'b0;
        src_cfg = 16'h5555; #1; check("R5", "all address", pin_out, 8'h3E);
        src_cfg = 16'hFFFF;
        ext_cs = 3'b101; #1; check("R6", "chip select 101", pin_out, 8'h05);
        ext_cs = 3'b111; #1; check("R6", "chip select only low pins", pin_out, 8'h07);
        ext_cs = 3'b010; #1; check("R5", "chip select 010", pin_out, 8'h02);
    endtask

    task automatic t_src_mixed;
        wr_reg(3'd3, 8'h11);
        @(negedge clk); ale = 1'b1; bus_addr = 8'h22;
        @(negedge clk); ale = 1'b0;
        mcell_out = 8'h44;
        ext_cs    = 3'b111;
        src_cfg   = 16'hE4E4; #1;
        check("R6", "mixed sources per pin", pin_out, 8'h77);
    endtask

    task automatic t_ctrl_force;
        src_cfg = 16'h0000;
        @(negedge clk); ale = 1'b1; bus_addr = 8'h0A;
        @(negedge clk); ale = 1'b0;
        wr_reg(3'd3, 8'hF0);
        wr_reg(3'd1, 8'h0F); #1;
        check("R7", "control forces address", pin_out, 8'hFA);
        src_cfg = 16'h00AA; mcell_out = 8'h05; #1;
        check("R7", "control overrides macrocell code", pin_out, 8'hFA);
        wr_reg(3'd1, 8'h00);
        src_cfg = 16'h0000;
    endtask

    task automatic t_latch;
        src_cfg = 16'h5555;
        @(negedge clk); ale = 1'b1; bus_addr = 8'hA5; #1;
        check("R8", "transparent while high", pin_out, 8'hA5);
        bus_addr = 8'h5B; #1;
        check("R8", "follows while high", pin_out, 8'h5B);
        @(negedge clk); ale = 1'b0; bus_addr = 8'h3C; #1;
        check("R8", "holds after fall", pin_out, 8'h5B);
        @(negedge clk); bus_addr = 8'hFF; #1;
        check("R8", "still holds", pin_out, 8'h5B);
        ale = 1'b1; #1;
        check("R8", "opens again", pin_out, 8'hFF);
        @(negedge clk); ale = 1'b0;
        src_cfg = 16'h0000;
    endtask

    task automatic t_oe;
        wr_reg(3'd2, 8'h0F);
        ext_oe = 8'h00; #1; check("R9", "dir only", pin_oe, 8'h0F);
        ext_oe = 8'h30; #1; check("R9", "dir or ext", pin_oe, 8'h3F);
        wr_reg(3'd2, 8'h00); #1; check("R9", "ext only", pin_oe, 8'h30);
        ext_oe = 8'h00; #1; check("R9", "none", pin_oe, 8'h00);
    endtask

    task automatic t_logic_in;
        pin_in = 8'h9E; #1; check("R10", "logic_in follows pin", logic_in, 8'h9E);
        pin_in = 8'h21; #1; check("R10", "logic_in follows change", logic_in, 8'h21);
    endtask

    task automatic t_ignored;
        logic [7:0] v;
        wr_reg(3'd1, 8'h00);
        wr_reg(3'd2, 8'h12);
        wr_reg(3'd3, 8'h34);
        src_cfg = 16'h0000;
        wr_reg(3'd0, 8'hFF);
        for (int k = 4; k < 8; k++) wr_reg(3'(k), 8'hFF);
        rd_reg(3'd1, v); check("R11", "ctrl untouched", v, 8'h00);
        rd_reg(3'd2, v); check("R11", "dir untouched", v, 8'h12);
        rd_reg(3'd3, v); check("R11", "dout untouched", v, 8'h34);
        check("R11", "pin_out untouched", pin_out, 8'h34);
        check("R11", "pin_oe untouched", pin_oe, 8'h12);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        rst = 1'b1; cpu_addr = '0; cpu_wr = 1'b0; cpu_wdata = '0;
        bus_addr = '0; ale = 1'b0; mcell_out = '0; ext_cs = '0;
        ext_oe = '0; src_cfg = '0; pin_in = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_regs;
        t_sync;
        t_rb_misc;
        t_src_uniform;
        t_src_mixed;
        t_ctrl_force;
        t_latch;
        t_oe;
        t_logic_in;
        t_ignored;
        done = 1'b1;
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run;
        end
    end

endmodule